// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the fetch side of a transmit DMA engine. Software keeps a singly linked list of frame descriptors in system memory. Each descriptor holds a link to the next one, a word reserved for software, a status word and a combined control/length word. Software points the block at the head of the list through a frame pointer register. The block then walks the list one descriptor at a time. For each descriptor it hands the frame length and payload address to a transmit datapath, waits for the datapath to finish, and writes the result back into the descriptor before it follows the link.

The list never runs dry. Its tail is always a descriptor that software still owns, and the walker treats that descriptor as the end marker. It parks there with the pointer register still holding that address. Later, software fills the marker in as a real frame, appends a fresh marker and writes the kick register. The walk then resumes from the parked address. An interrupt pulse marks every completed descriptor, and a phase field lets software see whether the engine is idle, fetching, transmitting or writing back.

Top module: `txd_chain_walker`

## Requirements
- R1: After reset the block is idle. No memory request and no datapath request is raised, `irq_done` is low, and both the frame pointer (register 0) and the phase field (register 2) read 0.
- R2: A write to register 0 while idle loads the frame pointer with its low ALIGN_BITS bits cleared and starts a walk at that address. While not idle, writes to register 0 or register 1 have no effect on the walk or on the pointer.
- R3: A descriptor is laid out as four 32-bit words relative to its aligned base: +0x0 next pointer, +0x4 software word, +0x8 status, +0xC control in bits 31:16 and frame length in bits 15:0. Bit 31 of the +0xC word is the owner flag, where 0 means owned by the block and 1 means owned by software.
- R4: A descriptor whose owner flag is 1 ends the walk. The block raises no datapath request for it, writes nothing to it and returns to idle, and the frame pointer then reads that descriptor's address.
- R5: A write to register 1 while idle restarts the walk from the address held in the frame pointer.
- R6: For a non-zero length, `tx_req` stays high with `tx_len` equal to the length and `tx_buf_addr` equal to the base plus BUF_OFS, both stable, until `tx_done` is seen. The `tx_status` value present with `tx_done` is recorded.
- R7: A zero-length descriptor raises no datapath request and is completed with the error flag set.
- R8: Writeback writes the status word first and then the control word, and finishes both before any access to the next descriptor. The status word is bit 31 = 1, bit 30 = zero-length error and the recorded datapath status in the low TXST_W bits, with all other bits 0. The control word is written back with bit 31 set and its other bits unchanged. The next-pointer word and the software word are never written.
- R9: Memory requests keep address, direction and write data stable while `mem_req_valid` is high and `mem_req_ready` is low. At most one transaction is outstanding, and read data is taken only on `mem_rd_valid`.
- R10: `irq_done` is a one-cycle pulse, raised once for each descriptor after its control word has been written back.
- R11: Register 2 bits 1:0 give the phase: 0 idle, 1 fetching, 2 transmitting, 3 writeback.
- R12: Descriptors are visited in next-pointer order, and the low ALIGN_BITS bits of a next pointer are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pointer, 1 kick, 2 phase |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register selected by reg_addr |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Read data |
| tx_req | output | 1 | Frame request to the datapath |
| tx_buf_addr | output | ADDR_W | Payload address |
| tx_len | output | 16 | Frame length in bytes |
| tx_done | input | 1 | Datapath completion pulse |
| tx_status | input | TXST_W | Datapath result code |
| irq_done | output | 1 | Descriptor completion pulse |

## Verification
The bench builds the block with ADDR_W=16, ALIGN_BITS=5, BUF_OFS=16 and TXST_W=12. The narrow address makes a 2 KB memory model hold the whole list. The 32-byte alignment lets the bench set garbage in the low bits of both the started pointer and the stored links and still expect the aligned walk. The 12-bit status exercises the padded packing of the status word. Random memory accept and read latencies and random datapath delays run across several resumed rounds of a list scattered through memory. Directed cases cover zero-length frames, pointer and kick writes while busy, and a kick against an unchanged end marker.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE, SQ_RD_CTL, SQ_RD_NXT, SQ_XMIT, SQ_WB_ST, SQ_WB_CTL
   } sq_state_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0, PH_FETCH = 2'd1, PH_XMIT = 2'd2, PH_WBACK = 2'd3
   } phase_e;

   localparam logic [1:0] RSEL_FPTR = 2'd0;
   localparam logic [1:0] RSEL_KICK = 2'd1;
   localparam logic [1:0] RSEL_STAT = 2'd2;

   localparam logic [3:0] OFS_NEXT = 4'h0;
   localparam logic [3:0] OFS_STAT = 4'h8;
   localparam logic [3:0] OFS_CTL  = 4'hC;

   localparam int OWN_BIT = 31;
   localparam int ERR_BIT = 30;
   localparam int LEN_W   = 16;
endpackage

// File: rtl/txd_mem_if.sv
`timescale 1ns/1ps
module txd_mem_if #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_go,
   input  logic              cmd_wr,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [31:0]       cmd_wdata,
   output logic              cmd_done,
   output logic [31:0]       cmd_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [31:0]       mem_req_wdata,
   input  logic              mem_rd_valid,
   input  logic [31:0]       mem_rd_data
);
   typedef enum logic [1:0] {MI_IDLE, MI_REQ, MI_WAIT} mi_state_e;

   mi_state_e         st;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       wdata_q;
   logic [31:0]       rdata_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= MI_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            MI_IDLE: begin
               if (cmd_go) begin
                  st      <= MI_REQ;
                  wr_q    <= cmd_wr;
                  addr_q  <= cmd_addr;
                  wdata_q <= cmd_wdata;
               end
            end
            MI_REQ: begin
               if (mem_req_ready) begin
                  if (wr_q) begin
                     st     <= MI_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     st <= MI_WAIT;
                  end
               end
            end
            MI_WAIT: begin
               if (mem_rd_valid) begin
                  st      <= MI_IDLE;
                  done_q  <= 1'b1;
                  rdata_q <= mem_rd_data;
               end
            end
            default: st <= MI_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (st == MI_REQ);
   assign mem_req_write = wr_q;
   assign mem_req_addr  = addr_q;
   assign mem_req_wdata = wdata_q;
   assign cmd_done      = done_q;
   assign cmd_rdata     = rdata_q;

   // R9: request fields held while waiting for acceptance
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_write) && $stable(mem_req_wdata));

   // R9: read data is only expected while a read is outstanding
   p_rd_only_waiting_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> st == MI_WAIT);

   // R9: the sequencer never issues a second transaction while one is open
   p_go_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |-> st == MI_IDLE);
endmodule

// File: rtl/txd_regs.sv
`timescale 1ns/1ps
module txd_regs
   import txd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 4
) (
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [ADDR_W-1:0] cur_ptr,
   input  logic [1:0]        phase,
   output logic              ld_ptr,
   output logic [ADDR_W-1:0] ld_val,
   output logic              kick
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << ALIGN_BITS;

   logic [31:0] ptr_word;

   generate
      if (ADDR_W < 32) begin : g_pad
         assign ptr_word = {{(32 - ADDR_W){1'b0}}, cur_ptr};
      end else begin : g_full
         assign ptr_word = cur_ptr;
      end
   endgenerate

   assign ld_ptr = reg_wr_en && (reg_addr == RSEL_FPTR);
   assign kick   = reg_wr_en && (reg_addr == RSEL_KICK);
   assign ld_val = reg_wdata[ADDR_W-1:0] & ALIGN_MASK;

   always_comb begin
      unique case (reg_addr)
         RSEL_FPTR: reg_rdata = ptr_word;
         RSEL_STAT: reg_rdata = {30'd0, phase};
         default:   reg_rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/txd_seq.sv
`timescale 1ns/1ps
module txd_seq
   import txd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 4,
   parameter int BUF_OFS    = 16,
   parameter int TXST_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_ptr,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              kick,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic [1:0]        phase,
   output logic              cmd_go,
   output logic              cmd_wr,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [31:0]       cmd_wdata,
   input  logic              cmd_done,
   input  logic [31:0]       cmd_rdata,
   output logic              tx_req,
   output logic [ADDR_W-1:0] tx_buf_addr,
   output logic [LEN_W-1:0]  tx_len,
   input  logic              tx_done,
   input  logic [TXST_W-1:0] tx_status,
   output logic              irq_done
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << ALIGN_BITS;
   localparam logic [ADDR_W-1:0] BUF_OFS_V  = ADDR_W'(BUF_OFS);
   localparam logic [31:0]       OWN_SET    = 32'h1 << OWN_BIT;

   sq_state_e         st;
   logic              pend;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] next_q;
   logic [31:0]       ctl_q;
   logic              err_q;
   logic [TXST_W-1:0] txst_q;
   logic              irq_q;
   logic [31:0]       stat_word;
   logic [3:0]        ofs;

   generate
      if (TXST_W < ERR_BIT) begin : g_stat_pad
         assign stat_word = {1'b1, err_q, {(ERR_BIT - TXST_W){1'b0}}, txst_q};
      end else begin : g_stat_full
         assign stat_word = {1'b1, err_q, txst_q};
      end
   endgenerate

   always_comb begin
      unique case (st)
         SQ_RD_NXT: ofs = OFS_NEXT;
         SQ_WB_ST:  ofs = OFS_STAT;
         default:   ofs = OFS_CTL;
      endcase
   end

   assign cmd_go    = !pend && (st == SQ_RD_CTL || st == SQ_RD_NXT ||
                                st == SQ_WB_ST  || st == SQ_WB_CTL);
   assign cmd_wr    = (st == SQ_WB_ST) || (st == SQ_WB_CTL);
   assign cmd_addr  = ptr_q | ADDR_W'(ofs);
   assign cmd_wdata = (st == SQ_WB_ST) ? stat_word : (ctl_q | OWN_SET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         pend   <= 1'b0;
         ptr_q  <= '0;
         next_q <= '0;
         ctl_q  <= '0;
         err_q  <= 1'b0;
         txst_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (cmd_go)   pend <= 1'b1;
         if (cmd_done) pend <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (ld_ptr) begin
                  ptr_q <= ld_val;
                  st    <= SQ_RD_CTL;
               end else if (kick) begin
                  st <= SQ_RD_CTL;
               end
            end
            SQ_RD_CTL: begin
               if (cmd_done) begin
                  if (cmd_rdata[OWN_BIT]) begin
                     st <= SQ_IDLE;
                  end else begin
                     ctl_q <= cmd_rdata;
                     st    <= SQ_RD_NXT;
                  end
               end
            end
            SQ_RD_NXT: begin
               if (cmd_done) begin
                  next_q <= cmd_rdata[ADDR_W-1:0] & ALIGN_MASK;
                  if (ctl_q[LEN_W-1:0] == '0) begin
                     err_q  <= 1'b1;
                     txst_q <= '0;
                     st     <= SQ_WB_ST;
                  end else begin
                     err_q <= 1'b0;
                     st    <= SQ_XMIT;
                  end
               end
            end
            SQ_XMIT: begin
               if (tx_done) begin
                  txst_q <= tx_status;
                  st     <= SQ_WB_ST;
               end
            end
            SQ_WB_ST: begin
               if (cmd_done) st <= SQ_WB_CTL;
            end
            SQ_WB_CTL: begin
               if (cmd_done) begin
                  irq_q <= 1'b1;
                  ptr_q <= next_q;
                  st    <= SQ_RD_CTL;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st)
         SQ_IDLE:               phase = PH_IDLE;
         SQ_RD_CTL, SQ_RD_NXT:  phase = PH_FETCH;
         SQ_XMIT:               phase = PH_XMIT;
         default:               phase = PH_WBACK;
      endcase
   end

   assign cur_ptr     = ptr_q;
   assign tx_req      = (st == SQ_XMIT);
   assign tx_len      = ctl_q[LEN_W-1:0];
   assign tx_buf_addr = ptr_q + BUF_OFS_V;
   assign irq_done    = irq_q;

   // R6: request and its fields held until the datapath finishes
   p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && !tx_done |=> tx_req && $stable(tx_len) && $stable(tx_buf_addr));

   // R7: a zero-length frame never reaches the datapath
   p_tx_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> tx_len != '0);

   // R10: completion interrupt lasts one cycle
   p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |=> !irq_done);
endmodule

// File: rtl/txd_chain_walker.sv
`timescale 1ns/1ps
module txd_chain_walker
   import txd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 4,
   parameter int BUF_OFS    = 16,
   parameter int TXST_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [31:0]       mem_req_wdata,
   input  logic              mem_rd_valid,
   input  logic [31:0]       mem_rd_data,
   output logic              tx_req,
   output logic [ADDR_W-1:0] tx_buf_addr,
   output logic [15:0]       tx_len,
   input  logic              tx_done,
   input  logic [TXST_W-1:0] tx_status,
   output logic              irq_done
);
   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must lie in 8..32");
      end
      if (ALIGN_BITS < 4 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
         $error("ALIGN_BITS must cover the four descriptor words");
      end
      if (TXST_W < 1 || TXST_W > ERR_BIT) begin : g_bad_txst
         $error("TXST_W must lie in 1..30");
      end
      if (BUF_OFS % 4 != 0) begin : g_bad_bufofs
         $error("BUF_OFS must be word aligned");
      end
   endgenerate

   logic              ld_ptr;
   logic [ADDR_W-1:0] ld_val;
   logic              kick;
   logic [ADDR_W-1:0] cur_ptr;
   logic [1:0]        phase;
   logic              cmd_go;
   logic              cmd_wr;
   logic [ADDR_W-1:0] cmd_addr;
   logic [31:0]       cmd_wdata;
   logic              cmd_done;
   logic [31:0]       cmd_rdata;

   txd_regs #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
      .reg_wr_en (reg_wr_en),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cur_ptr   (cur_ptr),
      .phase     (phase),
      .ld_ptr    (ld_ptr),
      .ld_val    (ld_val),
      .kick      (kick)
   );

   txd_seq #(
      .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .BUF_OFS(BUF_OFS), .TXST_W(TXST_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_ptr      (ld_ptr),
      .ld_val      (ld_val),
      .kick        (kick),
      .cur_ptr     (cur_ptr),
      .phase       (phase),
      .cmd_go      (cmd_go),
      .cmd_wr      (cmd_wr),
      .cmd_addr    (cmd_addr),
      .cmd_wdata   (cmd_wdata),
      .cmd_done    (cmd_done),
      .cmd_rdata   (cmd_rdata),
      .tx_req      (tx_req),
      .tx_buf_addr (tx_buf_addr),
      .tx_len      (tx_len),
      .tx_done     (tx_done),
      .tx_status   (tx_status),
      .irq_done    (irq_done)
   );

   txd_mem_if #(.ADDR_W(ADDR_W)) u_mem (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_go        (cmd_go),
      .cmd_wr        (cmd_wr),
      .cmd_addr      (cmd_addr),
      .cmd_wdata     (cmd_wdata),
      .cmd_done      (cmd_done),
      .cmd_rdata     (cmd_rdata),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_data   (mem_rd_data)
   );

   // R4: a parked walker leaves the memory port quiet
   p_idle_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_IDLE |-> !mem_req_valid);

   // R8: writes only ever land on the status or control word
   p_wr_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> mem_req_addr[3] == 1'b1);
endmodule

// File: tb/test_txd_chain_walker.sv
`timescale 1ns/1ps
module test_txd_chain_walker;
   localparam int AW = 16;
   localparam int AB = 5;
   localparam int BO = 16;
   localparam int SW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic [1:0]    reg_addr = 2'd2;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          mem_req_valid;
   logic          mem_req_ready;
   logic          mem_req_write;
   logic [AW-1:0] mem_req_addr;
   logic [31:0]   mem_req_wdata;
   logic          mem_rd_valid;
   logic [31:0]   mem_rd_data;
   logic          tx_req;
   logic [AW-1:0] tx_buf_addr;
   logic [15:0]   tx_len;
   logic          tx_done;
   logic [SW-1:0] tx_status;
   logic          irq_done;

   always #2.5 clk = ~clk;

   txd_chain_walker #(.ADDR_W(AW), .ALIGN_BITS(AB), .BUF_OFS(BO), .TXST_W(SW)) i_txd_chain_walker (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .tx_req(tx_req),
      .tx_buf_addr(tx_buf_addr), .tx_len(tx_len), .tx_done(tx_done),
      .tx_status(tx_status), .irq_done(irq_done)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [31:0] mem [0:511];
   logic [31:0] d_next [0:47];
   logic [31:0] d_sys  [0:47];
   logic [31:0] d_stat [0:47];
   logic [31:0] d_ctl  [0:47];
   logic [15:0] exp_len [0:63];
   logic [AW-1:0] exp_buf [0:63];
   int exp_n = 0;
   int got_n = 0;
   int irq_cnt = 0;
   int irq_bad = 0;
   int wr_cnt = 0;
   int txn_cnt = 0;
   int ord_bad = 0;
   int hold_bad = 0;
   int fld_bad = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] slot_addr(input int k);
      return AW'((1 + (k * 7) % 41) * 32);
   endfunction

   function automatic logic [SW-1:0] txst_of(input logic [15:0] len);
      return SW'(len * 16'd3 + 16'd5);
   endfunction

   function automatic logic [31:0] exp_stat_word(input logic [15:0] len);
      if (len == 16'd0) return 32'hC000_0000;
      return 32'h8000_0000 | 32'(txst_of(len));
   endfunction

   // memory responder: random accept and read latency
   bit taken = 1'b0, t_wr = 1'b0, rd_pend = 1'b0, h_wait = 1'b0, exp_ctl = 1'b0;
   logic [AW-1:0] t_addr, rd_addr, h_addr, exp_base;
   logic [31:0] t_wdata, h_wd;
   bit h_wr;
   int rd_cnt = 0;
   initial begin
      mem_req_ready = 1'b0;
      mem_rd_valid  = 1'b0;
      mem_rd_data   = '0;
      forever begin
         @(negedge clk);
         if (taken) begin
            txn_cnt++;
            if (t_wr) begin
               wr_cnt++;
               mem[t_addr[10:2]] = t_wdata;
               if (t_addr[4:0] == 5'h08) begin
                  if (exp_ctl) ord_bad++;
                  exp_ctl  = 1'b1;
                  exp_base = t_addr & ~AW'(31);
               end else if (t_addr[4:0] == 5'h0C) begin
                  if (!exp_ctl || (t_addr & ~AW'(31)) != exp_base) ord_bad++;
                  exp_ctl = 1'b0;
               end else begin
                  fld_bad++;
               end
            end else begin
               if (exp_ctl) ord_bad++;
               if (t_addr[4:0] != 5'h00 && t_addr[4:0] != 5'h0C) fld_bad++;
               rd_pend = 1'b1;
               rd_cnt  = int'($urandom % 3);
               rd_addr = t_addr;
            end
         end
         if (h_wait) begin
            if (!(mem_req_valid && mem_req_addr == h_addr && mem_req_write == h_wr
                  && mem_req_wdata == h_wd)) hold_bad++;
         end
         mem_rd_valid = 1'b0;
         if (rd_pend) begin
            if (rd_cnt == 0) begin
               mem_rd_valid = 1'b1;
               mem_rd_data  = mem[rd_addr[10:2]];
               rd_pend      = 1'b0;
            end else begin
               rd_cnt--;
            end
         end
         mem_req_ready = mem_req_valid && ($urandom % 3 != 0);
         taken   = mem_req_ready;
         t_wr    = mem_req_write;
         t_addr  = mem_req_addr;
         t_wdata = mem_req_wdata;
         h_wait  = mem_req_valid && !mem_req_ready;
         h_addr  = mem_req_addr;
         h_wr    = mem_req_write;
         h_wd    = mem_req_wdata;
      end
   end

   // datapath model
   bit dp_busy = 1'b0;
   int dp_cnt = 0;
   logic [15:0] dp_len;
   initial begin
      tx_done   = 1'b0;
      tx_status = '0;
      forever begin
         @(negedge clk);
         tx_done = 1'b0;
         if (dp_busy) begin
            if (dp_cnt == 0) begin
               tx_done   = 1'b1;
               tx_status = txst_of(dp_len);
               dp_busy   = 1'b0;
            end else begin
               dp_cnt--;
            end
         end else if (tx_req) begin
            if (got_n < exp_n) begin
               check(tx_len == exp_len[got_n], "R6 tx_len", 32'(tx_len), 32'(exp_len[got_n]));
               check(tx_buf_addr == exp_buf[got_n], "R12 tx_buf_addr order", 32'(tx_buf_addr), 32'(exp_buf[got_n]));
            end else begin
               check(1'b0, "R7 unexpected tx_req", 32'(tx_len), 32'd0);
            end
            if (reg_addr == 2'd2)
               check(reg_rdata[1:0] == 2'd2, "R11 phase while transmitting", reg_rdata, 32'd2);
            got_n++;
            dp_len  = tx_len;
            dp_busy = 1'b1;
            dp_cnt  = int'($urandom % 4);
         end
      end
   end

   // interrupt monitor
   bit irq_prev = 1'b0;
   initial begin
      forever begin
         @(negedge clk);
         if (irq_done) irq_cnt++;
         if (irq_done && irq_prev) irq_bad++;
         irq_prev = irq_done;
      end
   end

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_addr  = sel;
      reg_wdata = data;
      @(negedge clk);
      reg_wr_en = 1'b0;
      reg_addr  = 2'd2;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [31:0] val);
      @(negedge clk);
      reg_addr = sel;
      #0.5;
      val = reg_rdata;
      reg_addr = 2'd2;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (reg_rdata[1:0] != 2'd0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   // build descriptors k = first .. first+cnt-1, dummy at first+cnt
   task automatic build(input int first, input int cnt, input int zero_j);
      for (int j = 0; j <= cnt; j++) begin
         int k = first + j;
         logic [AW-1:0] a = slot_addr(k);
         logic [15:0] len;
         len = 16'(1 + $urandom % 200);
         if (j == zero_j || $urandom % 6 == 0) len = 16'd0;
         d_next[k] = 32'(slot_addr(k + 1)) | ((j == 1) ? 32'h14 : 32'h0);
         d_sys[k]  = $urandom;
         d_stat[k] = 32'h3EAD_0000 ^ 32'(k);
         d_ctl[k]  = {1'b0, 15'($urandom), len};
         if (j == cnt) d_ctl[k][31] = 1'b1;
         else if (len != 0) begin
            exp_len[exp_n] = len;
            exp_buf[exp_n] = a + AW'(BO);
            exp_n++;
         end
         mem[a[10:2]]       = d_next[k];
         mem[a[10:2] + 1]   = d_sys[k];
         mem[a[10:2] + 2]   = d_stat[k];
         mem[a[10:2] + 3]   = d_ctl[k];
      end
   endtask

   task automatic verify(input int first, input int cnt);
      logic [31:0] v;
      for (int j = 0; j < cnt; j++) begin
         int k = first + j;
         logic [AW-1:0] a = slot_addr(k);
         check(mem[a[10:2] + 2] == exp_stat_word(d_ctl[k][15:0]), "R8 R7 status word",
               mem[a[10:2] + 2], exp_stat_word(d_ctl[k][15:0]));
         check(mem[a[10:2] + 3] == (d_ctl[k] | 32'h8000_0000), "R8 control writeback",
               mem[a[10:2] + 3], d_ctl[k] | 32'h8000_0000);
         check(mem[a[10:2] + 1] == d_sys[k], "R8 software word untouched", mem[a[10:2] + 1], d_sys[k]);
         check(mem[a[10:2]] == d_next[k], "R8 next word untouched", mem[a[10:2]], d_next[k]);
      end
      begin
         int k = first + cnt;
         logic [AW-1:0] a = slot_addr(k);
         check(mem[a[10:2] + 2] == d_stat[k] && mem[a[10:2] + 3] == d_ctl[k],
               "R4 end marker untouched", mem[a[10:2] + 3], d_ctl[k]);
         reg_read(2'd0, v);
         check(v == 32'(a), "R4 pointer parks on marker", v, 32'(a));
      end
      check(got_n == exp_n, "R6 R12 datapath request count", 32'(got_n), 32'(exp_n));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=0", 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int base_k;
      int irq_before;
      int wr_before;
      int txn_before;
      int done_before;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 512; i++) mem[i] = 32'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check(!tx_req && !mem_req_valid && !irq_done, "R1 outputs quiet after reset",
            {29'd0, tx_req, mem_req_valid, irq_done}, 32'd0);
      reg_read(2'd2, v);
      check(v[1:0] == 2'd0, "R1 R11 phase idle", v, 32'd0);
      reg_read(2'd0, v);
      check(v == 32'd0, "R1 pointer zero", v, 32'd0);

      // first chain, started with garbage low bits (R2), busy writes ignored (R2)
      build(0, 6, 2);
      reg_write(2'd0, 32'(slot_addr(0)) | 32'h1B);
      repeat (3) @(negedge clk);
      reg_read(2'd2, v);
      check(v[1:0] != 2'd0, "R2 walker busy after start", v, 32'd1);
      reg_write(2'd0, 32'(slot_addr(40)));
      reg_write(2'd1, 32'd0);
      wait_idle();
      verify(0, 6);
      check(irq_cnt == 6, "R10 one pulse per descriptor", 32'(irq_cnt), 32'd6);

      // resume after software extends the marker (R5)
      build(6, 3, -1);
      repeat (10) @(negedge clk);
      check(txn_cnt > 0 && !mem_req_valid, "R4 stays parked until kicked", 32'(mem_req_valid), 32'd0);
      reg_write(2'd1, 32'd0);
      wait_idle();
      verify(6, 3);
      check(irq_cnt == 9, "R5 R10 resumed completions", 32'(irq_cnt), 32'd9);

      // kick against an unchanged marker (R4)
      irq_before = irq_cnt;
      wr_before  = wr_cnt;
      txn_before = txn_cnt;
      reg_write(2'd1, 32'd0);
      wait_idle();
      repeat (4) @(negedge clk);
      check(wr_cnt == wr_before, "R4 no write to marker", 32'(wr_cnt), 32'(wr_before));
      check(txn_cnt == txn_before + 1, "R4 single control read", 32'(txn_cnt), 32'(txn_before + 1));
      check(irq_cnt == irq_before, "R4 no interrupt at marker", 32'(irq_cnt), 32'(irq_before));

      // random resumed rounds
      base_k = 9;
      for (int r = 0; r < 5; r++) begin
         int cnt = 1 + int'($urandom % 5);
         done_before = irq_cnt;
         build(base_k, cnt, (r == 2) ? 0 : -1);
         reg_write(2'd1, 32'd0);
         wait_idle();
         verify(base_k, cnt);
         check(irq_cnt == done_before + cnt, "R10 round completions", 32'(irq_cnt), 32'(done_before + cnt));
         base_k += cnt;
      end

      repeat (4) @(negedge clk);
      check(ord_bad == 0, "R8 writeback ordering", 32'(ord_bad), 32'd0);
      check(fld_bad == 0, "R3 R8 accessed word offsets", 32'(fld_bad), 32'd0);
      check(hold_bad == 0, "R9 request held while not ready", 32'(hold_bad), 32'd0);
      check(irq_bad == 0, "R10 pulse width", 32'(irq_bad), 32'd0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule